// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the device-side control machine of a byte-wide parallel NOR flash emulator. It receives one synchronous write strobe per bus write cycle, each with an address and a data byte. It follows the fixed unlock conversation that guards every alteration of the array. When a conversation completes, it issues a single-clock start request. The request carries an operation code, the address and data of the final cycle, and the 4 KiB sector number taken from that address.

An external operation timer reports a running program or erase through `busy_in`. While that input is high the decoder drops every write, including the exit command. The decoder also reports its mode: plain read, identification, or busy. The memory array, the strobe synthesis and the real erase durations belong to neighbouring blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `start_o` is 0, `op_o` is 0 (none) and `mode_o` is 0 (read).
- R2: Command cycles compare only address bits 14:0. Bits above 14 never change a decision.
- R3: Three cycles 5555h/AAh, 2AAAh/55h, 5555h/A0h, followed by any fourth write, give `op_o`=1 (program). The request carries that fourth write's address and data. `start_o` is high for the one clock after the final write.
- R4: The five cycles 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, followed by data 30h at any address, give `op_o`=2 (sector erase). `op_sector_o` equals that address shifted right by 12.
- R5: The same five-cycle prefix followed by 10h at 5555h gives `op_o`=3 (chip erase).
- R6: The cycles AAh, 55h and 90h at 5555h give `op_o`=4 (identification entry). `mode_o` becomes 1 (identification) in the same clock.
- R7: Either a lone F0h write at any address, or AAh/55h followed by F0h at 5555h, gives `op_o`=5 (identification exit). `mode_o` returns to 0.
- R8: A write that breaks the expected sequence discards the partial sequence. It issues no request and leaves the identification mode unchanged.
- R9: The breaking write is judged again as a first cycle. A 5555h/AAh that breaks a sequence therefore opens a new one at once.
- R10: While `busy_in` is 1, writes cause no request, no mode change and no change of sequence position.
- R11: `mode_o` is 2 (busy) whenever `busy_in` is 1.
- R12: `op_o`, `op_addr_o`, `op_data_o` and `op_sector_o` hold their values between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One bus write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy_in | input | 1 | Program or erase in progress |
| start_o | output | 1 | One-clock operation request |
| op_o | output | 3 | Operation code of the last request |
| op_addr_o | output | ADDR_W | Address of the final cycle |
| op_data_o | output | 8 | Data of the final cycle |
| op_sector_o | output | ADDR_W-12 | Sector number of the final cycle |
| mode_o | output | 2 | 0 read, 1 identification, 2 busy |

## Verification
Two functions can fall in the same cycle: completing a command sequence, and the busy gate of a running operation. The bench raises `busy_in` exactly on the write that would finish a chip erase. It then expects no request, and expects the held sequence position to accept that final write again after busy falls.

A second collision is a deviating write that is also a valid opener. The bench breaks the erase prefix at each depth with 5555h/AAh. It then expects a complete program to follow from that same write, with no extra cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_ADDR_BITS = 15;
    localparam int SECTOR_SHIFT  = 12;

    localparam logic [CMD_ADDR_BITS-1:0] ADDR_KEY_A = 15'h5555;
    localparam logic [CMD_ADDR_BITS-1:0] ADDR_KEY_B = 15'h2AAA;

    localparam logic [7:0] DATA_KEY_A   = 8'hAA;
    localparam logic [7:0] DATA_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_PROG    = 8'hA0;
    localparam logic [7:0] CODE_ERASE   = 8'h80;
    localparam logic [7:0] CODE_ID_IN   = 8'h90;
    localparam logic [7:0] CODE_ID_OUT  = 8'hF0;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;
    localparam logic [7:0] CODE_CHIP    = 8'h10;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_PROG       = 3'd1,
        OP_SECT_ERASE = 3'd2,
        OP_CHIP_ERASE = 3'd3,
        OP_ID_ENTER   = 3'd4,
        OP_ID_EXIT    = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_ID   = 2'd1,
        MODE_BUSY = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_DATA,
        ST_ER_KEY0,
        ST_ER_KEY1,
        ST_ER_KEY2
    } seq_e;

    // Classified view of one bus write cycle
    typedef struct packed {
        logic       at_a;     // low address bits equal the first key address
        logic       key_a;    // first key pair
        logic       key_b;    // second key pair
        logic [7:0] data;
    } cycle_t;

    function automatic logic low_addr_eq(input logic [CMD_ADDR_BITS-1:0] a,
                                         input logic [CMD_ADDR_BITS-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output cycle_t            cyc
);
    localparam int LOW_W = (ADDR_W < CMD_ADDR_BITS) ? ADDR_W : CMD_ADDR_BITS;

    logic [CMD_ADDR_BITS-1:0] low;

    generate
        if (ADDR_W >= CMD_ADDR_BITS) begin : g_wide
            assign low = addr[CMD_ADDR_BITS-1:0];
        end else begin : g_narrow
            assign low = {{(CMD_ADDR_BITS-LOW_W){1'b0}}, addr[LOW_W-1:0]};
        end
    endgenerate

    always_comb begin
        cyc.data  = data;
        cyc.at_a  = low_addr_eq(low, ADDR_KEY_A);
        cyc.key_a = cyc.at_a && (data == DATA_KEY_A);
        cyc.key_b = low_addr_eq(low, ADDR_KEY_B) && (data == DATA_KEY_B);
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  cycle_t cyc,
    output op_e    op_n
);
    seq_e seq_q, seq_n;
    logic deviate;

    always_comb begin
        seq_n   = seq_q;
        op_n    = OP_NONE;
        deviate = 1'b0;
        if (fire) begin
            unique case (seq_q)
                ST_IDLE: deviate = 1'b1;
                ST_KEY1: begin
                    if (cyc.key_b) seq_n = ST_KEY2;
                    else           deviate = 1'b1;
                end
                ST_KEY2: begin
                    if (cyc.at_a && cyc.data == CODE_PROG)       seq_n = ST_PROG_DATA;
                    else if (cyc.at_a && cyc.data == CODE_ERASE) seq_n = ST_ER_KEY0;
                    else if (cyc.at_a && cyc.data == CODE_ID_IN) begin
                        op_n  = OP_ID_ENTER;
                        seq_n = ST_IDLE;
                    end else if (cyc.at_a && cyc.data == CODE_ID_OUT) begin
                        op_n  = OP_ID_EXIT;
                        seq_n = ST_IDLE;
                    end else deviate = 1'b1;
                end
                ST_PROG_DATA: begin
                    op_n  = OP_PROG;
                    seq_n = ST_IDLE;
                end
                ST_ER_KEY0: begin
                    if (cyc.key_a) seq_n = ST_ER_KEY1;
                    else           deviate = 1'b1;
                end
                ST_ER_KEY1: begin
                    if (cyc.key_b) seq_n = ST_ER_KEY2;
                    else           deviate = 1'b1;
                end
                ST_ER_KEY2: begin
                    if (cyc.data == CODE_SECTOR) begin
                        op_n  = OP_SECT_ERASE;
                        seq_n = ST_IDLE;
                    end else if (cyc.at_a && cyc.data == CODE_CHIP) begin
                        op_n  = OP_CHIP_ERASE;
                        seq_n = ST_IDLE;
                    end else deviate = 1'b1;
                end
                default: seq_n = ST_IDLE;
            endcase
            // A breaking write is judged again as a first cycle
            if (deviate) begin
                if (cyc.key_a) begin
                    seq_n = ST_KEY1;
                end else begin
                    seq_n = ST_IDLE;
                    if (cyc.data == CODE_ID_OUT) op_n = OP_ID_EXIT;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= ST_IDLE;
        else     seq_q <= seq_n;
    end

endmodule

// File: rtl/flash_mode_track.sv
module flash_mode_track
    import flash_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op_n,
    input  logic busy_in,
    output mode_e mode
);
    logic id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= 1'b0;
        end else begin
            if (op_n == OP_ID_ENTER)     id_q <= 1'b1;
            else if (op_n == OP_ID_EXIT) id_q <= 1'b0;
        end
    end

    always_comb begin
        if (busy_in)   mode = MODE_BUSY;
        else if (id_q) mode = MODE_ID;
        else           mode = MODE_READ;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    input  logic                     busy_in,
    output logic                     start_o,
    output logic [2:0]               op_o,
    output logic [ADDR_W-1:0]        op_addr_o,
    output logic [7:0]               op_data_o,
    output logic [ADDR_W-SECTOR_SHIFT-1:0] op_sector_o,
    output logic [1:0]               mode_o
);
    localparam int SECT_W = ADDR_W - SECTOR_SHIFT;

    cycle_t cyc;
    op_e    op_n;
    op_e    op_q;
    mode_e  mode;
    logic   fire;

    assign fire = wr_valid && !busy_in;

    flash_cmd_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .cyc  (cyc)
    );

    flash_cmd_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .cyc  (cyc),
        .op_n (op_n)
    );

    flash_mode_track u_mode (
        .clk     (clk),
        .rst     (rst),
        .op_n    (op_n),
        .busy_in (busy_in),
        .mode    (mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_o     <= 1'b0;
            op_q        <= OP_NONE;
            op_addr_o   <= '0;
            op_data_o   <= '0;
            op_sector_o <= '0;
        end else begin
            start_o <= (op_n != OP_NONE);
            if (op_n != OP_NONE) begin
                op_q        <= op_n;
                op_addr_o   <= wr_addr;
                op_data_o   <= wr_data;
                op_sector_o <= wr_addr[ADDR_W-1:SECTOR_SHIFT];
            end
        end
    end

    assign op_o   = op_q;
    assign mode_o = mode;

    logic unused_sect_w;
    assign unused_sect_w = (SECT_W > 0);

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_valid,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [7:0]                  wr_data,
    input logic                        busy_in,
    input logic                        start_o,
    input logic [2:0]                  op_o,
    input logic [ADDR_W-1:0]           op_addr_o,
    input logic [7:0]                  op_data_o,
    input logic [ADDR_W-SECTOR_SHIFT-1:0] op_sector_o,
    input logic [1:0]                  mode_o
);
    // R10: a write seen while busy never yields a request
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && busy_in) |=> !start_o);

    // R3: a request only follows a write
    assert_start_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !start_o);

    // R12: a request always carries a real operation
    assert_start_has_op_R12: assert property (@(posedge clk) disable iff (rst)
        start_o |-> (op_o != OP_NONE));

    // R3: program request carries the final write's address and data
    assert_prog_payload_R3: assert property (@(posedge clk) disable iff (rst)
        (start_o && op_o == OP_PROG) |->
            (op_addr_o == $past(wr_addr) && op_data_o == $past(wr_data)));

    // R4: sector erase only on data 30h
    assert_sector_code_R4: assert property (@(posedge clk) disable iff (rst)
        (start_o && op_o == OP_SECT_ERASE) |-> ($past(wr_data) == CODE_SECTOR));

    // R6: identification entry is visible in the mode output
    assert_id_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (start_o && op_o == OP_ID_ENTER) |-> (mode_o == MODE_ID || busy_in));

    // R11: busy input always shows as busy mode
    assert_busy_mode_R11: assert property (@(posedge clk) disable iff (rst)
        busy_in |-> (mode_o == MODE_BUSY));

    // R12: payload held between requests
    assert_hold_payload_R12: assert property (@(posedge clk) disable iff (rst)
        !start_o |-> ($stable(op_addr_o) || $past(rst)));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .busy_in     (busy_in),
    .start_o     (start_o),
    .op_o        (op_o),
    .op_addr_o   (op_addr_o),
    .op_data_o   (op_data_o),
    .op_sector_o (op_sector_o),
    .mode_o      (mode_o)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
    localparam int AW = 19;
    localparam int SW = AW - 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          busy_in = 1'b0;
    logic          start_o;
    logic [2:0]    op_o;
    logic [AW-1:0] op_addr_o;
    logic [7:0]    op_data_o;
    logic [SW-1:0] op_sector_o;
    logic [1:0]    mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(AW)) u_flash_cmd_decoder (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy_in(busy_in), .start_o(start_o), .op_o(op_o),
        .op_addr_o(op_addr_o), .op_data_o(op_data_o),
        .op_sector_o(op_sector_o), .mode_o(mode_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int hb, input logic [14:0] lo);
        return AW'((hb << 15) | int'(lo));
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // erase prefix cycle i (0..4)
    task automatic erase_pre(input int i, input int hb);
        case (i)
            0: wr(mk(hb, 15'h5555), 8'hAA);
            1: wr(mk(hb, 15'h2AAA), 8'h55);
            2: wr(mk(hb, 15'h5555), 8'h80);
            3: wr(mk(hb, 15'h5555), 8'hAA);
            default: wr(mk(hb, 15'h2AAA), 8'h55);
        endcase
    endtask

    task automatic expect_op(input string tag, input int op, input logic [AW-1:0] a,
                             input logic [7:0] d);
        chk({tag, " start"}, start_o, 1);
        chk({tag, " op"}, op_o, op);
        chk({tag, " addr"}, op_addr_o, a);
        chk({tag, " data"}, op_data_o, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 start", start_o, 0);
        chk("R1 op", op_o, 0);
        chk("R1 mode", mode_o, 0);

        // R3 and R2: program under varied high bits and data
        for (int hb = 0; hb < 16; hb += 5) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] d;
                logic [AW-1:0] a;
                d = (k == 0) ? 8'hF0 : (k == 1) ? 8'hAA : 8'(k * 37 + 1);
                a = AW'(hb * 4099 + k * 777);
                wr(mk(hb, 15'h5555), 8'hAA); chk("R3 no early start", start_o, 0);
                wr(mk(hb, 15'h2AAA), 8'h55); chk("R3 no early start", start_o, 0);
                wr(mk(hb, 15'h5555), 8'hA0); chk("R3 no early start", start_o, 0);
                wr(a, d);
                expect_op("R3 R2 program", 1, a, d);
                chk("R3 mode read", mode_o, 0);
            end
        end
        // R12 hold after request
        idle();
        chk("R12 start low", start_o, 0);
        chk("R12 op held", op_o, 1);

        // R4 and R2: sector erase, sector number sweep
        for (int hb = 0; hb < 16; hb++) begin
            logic [AW-1:0] sa;
            sa = mk(hb, 15'h1ABC + 15'(hb * 4096));
            for (int i = 0; i < 5; i++) erase_pre(i, 15 - hb);
            wr(sa, 8'h30);
            expect_op("R4 sector", 2, sa, 8'h30);
            chk("R4 sector number", op_sector_o, 32'(sa) >> 12);
        end

        // R5 chip erase with high bits set
        for (int i = 0; i < 5; i++) erase_pre(i, 7);
        wr(mk(9, 15'h5555), 8'h10);
        expect_op("R5 chip", 3, mk(9, 15'h5555), 8'h10);

        // R8: break the erase prefix at every depth, then a chip erase works
        for (int pos = 0; pos < 5; pos++) begin
            for (int i = 0; i < pos; i++) erase_pre(i, 0);
            wr(AW'(15'h1234), 8'h00);
            chk("R8 abort no start", start_o, 0);
            for (int i = 0; i < 5; i++) erase_pre(i, 0);
            wr(mk(0, 15'h5555), 8'h10);
            chk("R8 fresh chip start", start_o, 1);
            chk("R8 fresh chip op", op_o, 3);
        end
        // R8: chip code at wrong address is a deviation
        for (int i = 0; i < 5; i++) erase_pre(i, 0);
        wr(AW'(15'h0555), 8'h10);
        chk("R8 chip wrong addr", start_o, 0);

        // R9: breaking write 5555/AA restarts immediately
        for (int p = 0; p < 4; p++) begin
            int pos;
            pos = (p < 2) ? p + 1 : p + 2;
            for (int i = 0; i < pos; i++) erase_pre(i, 0);
            wr(mk(0, 15'h5555), 8'hAA);
            chk("R9 no start", start_o, 0);
            wr(mk(0, 15'h2AAA), 8'h55);
            wr(mk(0, 15'h5555), 8'hA0);
            wr(AW'(pos * 3 + 100), 8'h3C);
            expect_op("R9 restart program", 1, AW'(pos * 3 + 100), 8'h3C);
        end

        // R6 identification entry
        wr(mk(3, 15'h5555), 8'hAA);
        wr(mk(3, 15'h2AAA), 8'h55);
        wr(mk(3, 15'h5555), 8'h90);
        chk("R6 op", op_o, 4);
        chk("R6 start", start_o, 1);
        chk("R6 mode id", mode_o, 1);
        // R8 deviation keeps identification mode
        wr(mk(0, 15'h5555), 8'hAA);
        wr(AW'(15'h0001), 8'h77);
        chk("R8 mode kept", mode_o, 1);
        // R7 lone exit
        wr(AW'(15'h7777), 8'hF0);
        chk("R7 lone exit op", op_o, 5);
        chk("R7 lone exit mode", mode_o, 0);
        // R7 three-cycle exit
        wr(mk(0, 15'h5555), 8'hAA); wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'h90);
        chk("R6 re-entry", mode_o, 1);
        wr(mk(0, 15'h5555), 8'hAA); wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'hF0);
        chk("R7 long exit op", op_o, 5);
        chk("R7 long exit mode", mode_o, 0);

        // R10 and R11: busy ignores exit and holds sequence position
        wr(mk(0, 15'h5555), 8'hAA); wr(mk(0, 15'h2AAA), 8'h55); wr(mk(0, 15'h5555), 8'h90);
        busy_in = 1'b1;
        @(negedge clk);
        chk("R11 busy mode", mode_o, 2);
        wr(AW'(15'h0000), 8'hF0);
        chk("R10 exit ignored start", start_o, 0);
        busy_in = 1'b0;
        @(negedge clk);
        chk("R10 still id", mode_o, 1);
        wr(AW'(15'h0000), 8'hF0);
        wr(mk(0, 15'h5555), 8'hAA); wr(mk(0, 15'h2AAA), 8'h55);
        busy_in = 1'b1;
        wr(AW'(15'h1234), 8'h00);
        chk("R10 junk ignored", start_o, 0);
        busy_in = 1'b0;
        wr(mk(0, 15'h5555), 8'hA0);
        wr(AW'(15'h0042), 8'h5A);
        expect_op("R10 position held", 1, AW'(15'h0042), 8'h5A);

        // R10: busy coincides with the final chip erase write
        for (int i = 0; i < 5; i++) erase_pre(i, 0);
        busy_in = 1'b1;
        wr(mk(0, 15'h5555), 8'h10);
        chk("R10 final write blocked", start_o, 0);
        busy_in = 1'b0;
        wr(mk(0, 15'h5555), 8'h10);
        chk("R10 final write retried", op_o, 3);
        chk("R10 final write start", start_o, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule